// File: doc/BRIEF.md
# General-Purpose Input Event Router

This block watches sixteen general-purpose input status bits. It steers each one to a system management interrupt request, a system control interrupt request, or to neither. A 32-bit read/write routing register holds a 2-bit route field for each input slot. An input raises its routed interrupt only when three conditions hold together: its status bit is set, its per-input event enable is set, and its pin is configured as an input.

Wake generation does not depend on the route. While the platform reports that it is asleep, any implemented input with both status and enable set requests a wake, even when its route field is 00. Six input slots (2, 3, 4, 10, 14 and 15) are not implemented. Their route bits are not stored and they never cause an event.

Latching of the status bits, the pin logic and the downstream interrupt controller sit outside this block. Each of the three outputs is a combinational level formed from the routing register and the current inputs.

Top module: `gpi_route_ctrl`

## Requirements
- R1: After reset the routing register reads as all zeros, and smi_req and sci_req are low.
- R2: A write with wr_en high updates, at the next rising clock edge, only the register bytes whose wr_be bit is set (bit k covers data bits [8k+7:8k]). Input n is routed by bits [2n+1:2n], and rd_data shows the stored register at all times.
- R3: Slots 2, 3, 4, 10, 14 and 15 store nothing and read back as zero. They never raise smi_req, sci_req or wake_req.
- R4: Route code 01 on input n raises smi_req when gpi_sts[n], gpi_en[n] and gpio_in_dir[n] are all 1.
- R5: Route code 10 on input n raises sci_req under the same three conditions.
- R6: Route codes 00 and 11 raise neither smi_req nor sci_req.
- R7: When gpio_in_dir[n] is 0, the route field of input n has no effect on smi_req or sci_req.
- R8: Input n causes no smi_req, sci_req or wake_req unless both gpi_sts[n] and gpi_en[n] are 1.
- R9: While sleeping is 1, any implemented input with status and enable both set drives wake_req high, whatever its route code and direction.
- R10: wake_req is 0 while sleeping is 0.
- R11: smi_req and sci_req are level outputs. Each is the OR over all inputs that qualify, and it stays high for as long as any qualifying condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current routing register contents |
| gpi_sts | input | 16 | Per-input latched status |
| gpi_en | input | 16 | Per-input event enable |
| gpio_in_dir | input | 16 | 1 = pin configured as input |
| sleeping | input | 1 | 1 = system in a sleeping state |
| smi_req | output | 1 | System management interrupt request level |
| sci_req | output | 1 | System control interrupt request level |
| wake_req | output | 1 | Wake request level |

## Verification
Random route words, status, enable and direction patterns are checked against a bench model. These cases separate the SMI path from the SCI path and catch any swap between the two route codes. Directed patterns fill every field with 11, clear the direction bits while routes are valid, or clear only the enables; each one isolates a single gating term. Routing an unimplemented slot with every condition set shows whether that slot leaks, and toggling sleeping with every route at 00 shows that wake does not depend on the route fields. Partial byte-enable writes expose any byte-lane mix-up in the register.

// File: rtl/gpi_route_pkg.sv
package gpi_route_pkg;
  localparam int GPI_CNT   = 16;
  localparam int FIELD_W   = 2;
  localparam int REG_W     = GPI_CNT * FIELD_W;
  localparam int BYTE_CNT  = REG_W / 8;
  // implemented slots: 0,1,5,6,7,8,9,11,12,13
  localparam logic [GPI_CNT-1:0] IMPL_SLOTS = 16'h3BE3;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'b00,
    ROUTE_SMI  = 2'b01,
    ROUTE_SCI  = 2'b10,
    ROUTE_RSVD = 2'b11
  } route_e;

  function automatic logic route_is_smi(input logic [1:0] code);
    return code == ROUTE_SMI;
  endfunction

  function automatic logic route_is_sci(input logic [1:0] code);
    return code == ROUTE_SCI;
  endfunction

  // widen a per-slot mask to a per-bit mask of the routing register
  function automatic logic [REG_W-1:0] slot_to_bits(input logic [GPI_CNT-1:0] slots);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < GPI_CNT; i++) r[i*FIELD_W +: FIELD_W] = {FIELD_W{slots[i]}};
    return r;
  endfunction
endpackage

// File: rtl/gpi_route_regs.sv
module gpi_route_regs
  import gpi_route_pkg::*;
#(
  parameter int                  N_SLOTS = GPI_CNT,
  parameter logic [N_SLOTS-1:0]  IMPL    = IMPL_SLOTS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [N_SLOTS*2/8-1:0] wr_be,
  input  logic [N_SLOTS*2-1:0]   wr_data,
  output logic [N_SLOTS*2-1:0]   route_q
);
  localparam int W  = N_SLOTS * 2;
  localparam int NB = W / 8;
  localparam logic [W-1:0] KEEP = slot_to_bits(IMPL);

  logic [W-1:0] lane_mask;
  logic [W-1:0] route_d;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{wr_en & wr_be[b]}};
  end

  assign route_d = ((route_q & ~lane_mask) | (wr_data & lane_mask)) & KEEP;

  always_ff @(posedge clk) begin
    if (!rst_n) route_q <= '0;
    else        route_q <= route_d;
  end

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wr_be)) |=> route_q == ($past(wr_data) & KEEP));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(route_q));
  // R3
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q & ~KEEP) == '0);
endmodule

// File: rtl/gpi_route_qual.sv
module gpi_route_qual
  import gpi_route_pkg::*;
#(
  parameter int                 N_SLOTS = GPI_CNT,
  parameter logic [N_SLOTS-1:0] IMPL    = IMPL_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SLOTS*2-1:0] route_q,
  input  logic [N_SLOTS-1:0]   sts,
  input  logic [N_SLOTS-1:0]   en,
  input  logic [N_SLOTS-1:0]   dir_in,
  output logic [N_SLOTS-1:0]   smi_hit,
  output logic [N_SLOTS-1:0]   sci_hit,
  output logic [N_SLOTS-1:0]   wake_hit
);
  logic [N_SLOTS-1:0] sel_smi, sel_sci, armed;

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    assign sel_smi[i] = route_is_smi(route_q[i*2 +: 2]);
    assign sel_sci[i] = route_is_sci(route_q[i*2 +: 2]);
  end

  assign armed    = sts & en & IMPL;
  assign wake_hit = armed;
  assign smi_hit  = armed & dir_in & sel_smi;
  assign sci_hit  = armed & dir_in & sel_sci;

  // R5
  no_double_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_hit & sci_hit) == '0);
  // R7
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((smi_hit | sci_hit) & ~dir_in) == '0);
  // R8
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((smi_hit | sci_hit | wake_hit) & ~(sts & en)) == '0);
  // R3
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((smi_hit | sci_hit | wake_hit) & ~IMPL) == '0);
endmodule

// File: rtl/gpi_route_ctrl.sv
module gpi_route_ctrl
  import gpi_route_pkg::*;
#(
  parameter int                 N_SLOTS = GPI_CNT,
  parameter logic [N_SLOTS-1:0] IMPL    = IMPL_SLOTS,
  localparam int                W       = N_SLOTS * 2,
  localparam int                NB      = W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NB-1:0]      wr_be,
  input  logic [W-1:0]       wr_data,
  output logic [W-1:0]       rd_data,
  input  logic [N_SLOTS-1:0] gpi_sts,
  input  logic [N_SLOTS-1:0] gpi_en,
  input  logic [N_SLOTS-1:0] gpio_in_dir,
  input  logic               sleeping,
  output logic               smi_req,
  output logic               sci_req,
  output logic               wake_req
);
  logic [W-1:0]       route_q;
  logic [N_SLOTS-1:0] smi_hit, sci_hit, wake_hit;

  gpi_route_regs #(.N_SLOTS(N_SLOTS), .IMPL(IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .route_q(route_q)
  );

  gpi_route_qual #(.N_SLOTS(N_SLOTS), .IMPL(IMPL)) u_qual (
    .clk(clk), .rst_n(rst_n), .route_q(route_q), .sts(gpi_sts), .en(gpi_en),
    .dir_in(gpio_in_dir), .smi_hit(smi_hit), .sci_hit(sci_hit), .wake_hit(wake_hit)
  );

  assign rd_data  = route_q;
  assign smi_req  = |smi_hit;
  assign sci_req  = |sci_hit;
  assign wake_req = sleeping & (|wake_hit);

  // R10
  wake_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> sleeping);
  // R4
  smi_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> |(gpi_sts & gpi_en & gpio_in_dir));
  // R11
  sci_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sci_req && $stable(route_q) && $stable(gpi_sts) && $stable(gpi_en) &&
     $stable(gpio_in_dir)) |=> (sci_req || !$stable(route_q) || !$stable(gpi_sts) ||
     !$stable(gpi_en) || !$stable(gpio_in_dir)));
endmodule

// File: tb/gpi_route_ctrl_test.sv
module gpi_route_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [15:0] gpi_sts = 0, gpi_en = 0, gpio_in_dir = 0;
  logic        sleeping = 0;
  logic        smi_req, sci_req, wake_req;

  int vec_cnt = 0;
  int bad_cnt = 0;
  logic [31:0] shadow = 0;

  always #5 clk = ~clk;

  gpi_route_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .rd_data(rd_data), .gpi_sts(gpi_sts), .gpi_en(gpi_en),
    .gpio_in_dir(gpio_in_dir), .sleeping(sleeping), .smi_req(smi_req),
    .sci_req(sci_req), .wake_req(wake_req)
  );

  function automatic logic [15:0] live_slots();
    logic [15:0] m = 16'hFFFF;
    m[2] = 0; m[3] = 0; m[4] = 0; m[10] = 0; m[14] = 0; m[15] = 0;
    return m;
  endfunction

  function automatic logic [31:0] live_bits();
    logic [31:0] b = 0;
    for (int s = 0; s < 16; s++) if (live_slots()[s]) b[2*s +: 2] = 2'b11;
    return b;
  endfunction

  function automatic logic want_out(input logic [31:0] rt, input logic [1:0] code);
    logic any = 0;
    for (int s = 0; s < 16; s++)
      if (live_slots()[s] && gpi_sts[s] && gpi_en[s] && gpio_in_dir[s] &&
          rt[2*s +: 2] == code) any = 1;
    return any;
  endfunction

  function automatic logic want_wake();
    return sleeping && |(gpi_sts & gpi_en & live_slots());
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] be, input logic [31:0] d,
                      input logic [15:0] st, input logic [15:0] en,
                      input logic [15:0] dr, input logic slp);
    @(negedge clk);
    wr_en = we; wr_be = be; wr_data = d;
    gpi_sts = st; gpi_en = en; gpio_in_dir = dr; sleeping = slp;
    @(posedge clk); #1;
    if (we) begin
      for (int k = 0; k < 4; k++) if (be[k]) shadow[8*k +: 8] = d[8*k +: 8];
      shadow &= live_bits();
    end
    check(rd_data, shadow, "R2");
    check({31'b0, smi_req}, {31'b0, want_out(shadow, 2'b01)}, "R4");
    check({31'b0, sci_req}, {31'b0, want_out(shadow, 2'b10)}, "R5");
    check({31'b0, wake_req}, {31'b0, want_wake()}, "R9");
  endtask

  initial begin
    #200000;
    bad_cnt++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    check(rd_data, 32'h0, "R1");
    check({smi_req, sci_req}, 2'b00, "R1");

    // R3 unimplemented slots drop written bits
    step(1, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    check(rd_data, live_bits(), "R3");
    // R6 code 11 everywhere, all conditions set
    step(0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    check({smi_req, sci_req}, 2'b00, "R6");
    // R2 byte lane: only byte 1 to SCI code
    step(1, 4'b0010, 32'h00AA_AA00, 0, 0, 0, 0);
    check(rd_data, (32'hFFFF_AAFF & live_bits()), "R2");
    // R7 all SMI route, no inputs configured
    step(1, 4'hF, 32'h5555_5555, 16'hFFFF, 16'hFFFF, 16'h0000, 0);
    check({smi_req, sci_req}, 2'b00, "R7");
    // R8 enables clear
    step(0, 0, 0, 16'hFFFF, 16'h0000, 16'hFFFF, 1);
    check({smi_req, wake_req}, 2'b00, "R8");
    // R3 only slot 4 armed (unimplemented)
    step(0, 0, 0, 16'h0010, 16'h0010, 16'h0010, 1);
    check({smi_req, wake_req}, 2'b00, "R3");
    // R9 wake with route 00
    step(1, 4'hF, 32'h0, 16'h0001, 16'h0001, 16'h0000, 1);
    check({31'b0, wake_req}, 32'h1, "R9");
    // R10 no wake while awake
    step(0, 0, 0, 16'h0001, 16'h0001, 16'h0001, 0);
    check({31'b0, wake_req}, 32'h0, "R10");
    // R11 level holds over cycles: slot 13 to SMI
    step(1, 4'hF, 32'h0400_0000, 16'h2000, 16'h2000, 16'h2000, 0);
    for (int c = 0; c < 4; c++) begin
      step(0, 0, 0, 16'h2000, 16'h2000, 16'h2000, 0);
      check({31'b0, smi_req}, 32'h1, "R11");
    end

    for (int n = 0; n < 400; n++)
      step($urandom_range(0, 3) == 0, 4'($urandom), $urandom,
           16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule